// File: doc/BRIEF.md
# Waveform Sample Capture Unit

This block taps one of the internal per-phase sample streams of a metering datapath. The candidate streams are current, voltage, active-power, reactive-power and apparent-power multiplier outputs. It thins the chosen stream down to one of four output rates and latches each kept sample into a 24-bit holding register. It then flags the host through an active-low interrupt line. The host fetches the sample one byte per read strobe, top byte first. It then acknowledges by reading the status register, which releases the interrupt and clears the overrun flag.

The unit only observes the streams. It has no ready or stall signal toward the source, so energy accumulation further down the chip continues untouched while samples are taken. A base-rate strobe marks each new set of stream values. The decimator counts every strobe and keeps one in 1, 2, 4 or 8.

Top module: `wave_capture`

## Requirements
- R1: The stream vector holds N_PHASE×N_SRC lanes of 24 bits. Lane (phase×5 + source) sits at bits [(phase×5+source)×24 +: 24]. Source code 0 selects current, 1 voltage, 2 active power, 3 reactive power and 4 apparent power. Phase codes 0, 1 and 2 select that phase.
- R2: With phase code 3 or source code 5, 6 or 7, a strobe captures nothing. The held sample (seen on `byte_out`) is unchanged, and no interrupt is raised.
- R3: Rate code k (0..3) keeps one strobe in 2^k. A 3-bit counter, cleared by reset, advances on every strobe whatever the selection. A strobe is kept when the low k bits of the counter are zero, so the first strobe after reset is kept.
- R4: A kept strobe sampled at a clock edge loads the holding register at that edge. Before that edge `byte_out` still shows the old sample.
- R5: After a capture, `byte_out` shows bits 23:16. Each `byte_rd` pulse advances the output to 15:8 and then to 7:0. A further pulse wraps it back to 23:16.
- R6: A capture records a pending sample. `irq_n` is low exactly when a sample is pending and `irq_mask` is 1. With the mask at 0 the line stays high, and a pending sample shows as soon as the mask is set.
- R7: A pending sample stays pending until a `status_rd` pulse clears it. When a capture and `status_rd` fall in the same cycle, the capture wins and `irq_n` stays low.
- R8: A capture returns the byte pointer to the top byte. A capture that arrives after at least one `byte_rd` but before the pointer has wrapped sets `overrun`. `status_rd` without a capture in the same cycle clears `overrun`.
- R9: After reset, `irq_n` is 1, `overrun` is 0 and `byte_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Base-rate strobe: new stream values present |
| streams | input | 360 | All phase/source sample lanes, 24 bits each |
| phase_sel | input | 2 | Phase choice (3 = none) |
| src_sel | input | 3 | Source choice (5..7 = none) |
| rate_sel | input | 2 | Decimation exponent |
| irq_mask | input | 1 | Sample interrupt enable |
| status_rd | input | 1 | Status read with clear |
| byte_rd | input | 1 | Advance to next sample byte |
| byte_out | output | 8 | Current byte of held sample |
| irq_n | output | 1 | Active-low sample interrupt |
| overrun | output | 1 | Sample overwritten mid-read |

## Verification
Several properties are checked on every cycle:
- the interrupt line stays high while the mask is clear;
- a raised interrupt persists until a status read;
- a strobe with an invalid phase or source leaves the output byte untouched;
- overrun can only rise from a pointer that is part way through a sample;
- a status read with no capture in the same cycle clears overrun.

Which lane a code pair selects, the 1-in-2^k keep pattern, the byte order with its wrap, and the capture-versus-clear collision are shown only by the bench's directed scenarios, which compare against values computed from the lane layout and the strobe count.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
  localparam int PH_W   = 2;
  localparam int SRC_W  = 3;
  localparam int RATE_W = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_CURRENT  = 3'd0,
    SRC_VOLTAGE  = 3'd1,
    SRC_ACTIVE   = 3'd2,
    SRC_REACTIVE = 3'd3,
    SRC_APPARENT = 3'd4
  } wcap_src_e;
endpackage

// File: rtl/wcap_mux.sv
module wcap_mux
  import wcap_pkg::*;
#(
  parameter int SMP_W   = 24,
  parameter int N_PHASE = 3,
  parameter int N_SRC   = 5
) (
  input  logic [N_PHASE*N_SRC*SMP_W-1:0] streams,
  input  logic [PH_W-1:0]                phase_sel,
  input  logic [SRC_W-1:0]               src_sel,
  output logic [SMP_W-1:0]               sel_data,
  output logic                           sel_ok
);
  localparam int N_LANE = N_PHASE * N_SRC;
  localparam int IDX_W  = $clog2(N_LANE);

  logic [SMP_W-1:0] lane [N_LANE];
  logic [IDX_W-1:0] idx;

  for (genvar k = 0; k < N_LANE; k++) begin : g_lane
    assign lane[k] = streams[k*SMP_W +: SMP_W];
  end

  always_comb begin
    sel_ok = (32'(phase_sel) < N_PHASE) && (32'(src_sel) < N_SRC);
    idx    = '0;
    if (sel_ok) idx = IDX_W'(32'(phase_sel) * N_SRC + 32'(src_sel));
    sel_data = lane[idx];
  end
endmodule

// File: rtl/wcap_decim.sv
module wcap_decim
  import wcap_pkg::*;
#(
  parameter int CNT_W = (1 << RATE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              take
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] keep_mask;

  always_comb begin
    for (int i = 0; i < CNT_W; i++) keep_mask[i] = (i < 32'(rate_sel));
    take  = strobe && ((cnt_q & keep_mask) == '0);
    cnt_d = cnt_q;
    if (strobe) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/wcap_hold.sv
module wcap_hold #(
  parameter int SMP_W = 24,
  parameter int NB    = SMP_W / 8,
  parameter int PTR_W = $clog2(NB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SMP_W-1:0] din,
  input  logic             byte_rd,
  input  logic             status_rd,
  input  logic             irq_mask,
  output logic [7:0]       byte_out,
  output logic             irq_n,
  output logic             overrun,
  output logic [PTR_W-1:0] ptr
);
  logic [SMP_W-1:0] hold_q, hold_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             pend_q, pend_d;
  logic             ovr_q, ovr_d;

  always_comb begin
    hold_d = hold_q;
    ptr_d  = ptr_q;
    pend_d = pend_q;
    ovr_d  = ovr_q;
    if (status_rd) begin
      pend_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (load) begin
      hold_d = din;
      ptr_d  = '0;
      pend_d = 1'b1;
      if (ptr_q != '0) ovr_d = 1'b1;
    end else if (byte_rd) begin
      ptr_d = (ptr_q == PTR_W'(NB-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ptr_q  <= '0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      ptr_q  <= ptr_d;
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
    end
  end

  always_comb begin
    byte_out = '0;
    for (int b = 0; b < NB; b++)
      if (ptr_q == PTR_W'(b)) byte_out = hold_q[SMP_W-8-8*b +: 8];
    irq_n   = ~(pend_q & irq_mask);
    overrun = ovr_q;
    ptr     = ptr_q;
  end
endmodule

// File: rtl/wave_capture.sv
module wave_capture
  import wcap_pkg::*;
#(
  parameter int SMP_W   = 24,
  parameter int N_PHASE = 3,
  parameter int N_SRC   = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           smp_valid,
  input  logic [N_PHASE*N_SRC*SMP_W-1:0] streams,
  input  logic [PH_W-1:0]                phase_sel,
  input  logic [SRC_W-1:0]               src_sel,
  input  logic [RATE_W-1:0]              rate_sel,
  input  logic                           irq_mask,
  input  logic                           status_rd,
  input  logic                           byte_rd,
  output logic [7:0]                     byte_out,
  output logic                           irq_n,
  output logic                           overrun
);
  localparam int NB    = SMP_W / 8;
  localparam int PTR_W = $clog2(NB);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic [SMP_W-1:0] sel_data;
  logic             sel_ok;
  logic             take;
  logic [PTR_W-1:0] rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  wcap_mux #(.SMP_W(SMP_W), .N_PHASE(N_PHASE), .N_SRC(N_SRC)) u_mux (
    .streams  (streams),
    .phase_sel(phase_sel),
    .src_sel  (src_sel),
    .sel_data (sel_data),
    .sel_ok   (sel_ok)
  );

  wcap_decim u_decim (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .strobe  (smp_valid),
    .rate_sel(rate_sel),
    .take    (take)
  );

  wcap_hold #(.SMP_W(SMP_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (take & sel_ok),
    .din      (sel_data),
    .byte_rd  (byte_rd),
    .status_rd(status_rd),
    .irq_mask (irq_mask),
    .byte_out (byte_out),
    .irq_n    (irq_n),
    .overrun  (overrun),
    .ptr      (rd_ptr)
  );
endmodule

// File: rtl/wcap_checker.sv
module wcap_checker #(
  parameter int PTR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic [1:0]       phase_sel,
  input logic [2:0]       src_sel,
  input logic             irq_mask,
  input logic             status_rd,
  input logic             byte_rd,
  input logic [7:0]       byte_out,
  input logic             irq_n,
  input logic             overrun,
  input logic [PTR_W-1:0] ptr
);
  logic bad_sel;
  assign bad_sel = (phase_sel == 2'd3) || (src_sel > 3'd4);

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> irq_n); // R6

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask && $past(irq_mask) && !$past(irq_n) && !$past(status_rd)) |-> !irq_n); // R7

  AST_BAD_SEL_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && bad_sel && !byte_rd) |=> $stable(byte_out)); // R2

  AST_OVR_FROM_MIDREAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(ptr) != '0)); // R8

  AST_STATUS_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !smp_valid) |=> !overrun); // R8
endmodule

bind wave_capture wcap_checker #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_valid(smp_valid),
  .phase_sel(phase_sel),
  .src_sel  (src_sel),
  .irq_mask (irq_mask),
  .status_rd(status_rd),
  .byte_rd  (byte_rd),
  .byte_out (byte_out),
  .irq_n    (irq_n),
  .overrun  (overrun),
  .ptr      (rd_ptr)
);

// File: tb/wave_capture_bench.sv
`timescale 1ns/1ps
module wave_capture_bench;
  localparam int W = 24;
  localparam int NP = 3;
  localparam int NS = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            smp_valid;
  logic [NP*NS*W-1:0] streams;
  logic [1:0]      phase_sel;
  logic [2:0]      src_sel;
  logic [1:0]      rate_sel;
  logic            irq_mask;
  logic            status_rd;
  logic            byte_rd;
  logic [7:0]      byte_out;
  logic            irq_n;
  logic            overrun;

  int checks = 0;
  int failures = 0;
  int strobes = 0;
  logic [W-1:0] last;

  always #2.5 clk = ~clk;

  wave_capture u_wave_capture (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .streams(streams),
    .phase_sel(phase_sel), .src_sel(src_sel), .rate_sel(rate_sel),
    .irq_mask(irq_mask), .status_rd(status_rd), .byte_rd(byte_rd),
    .byte_out(byte_out), .irq_n(irq_n), .overrun(overrun)
  );

  function automatic logic [W-1:0] val(int p, int s, int seq);
    return {8'(seq), 4'(p), 4'(s), 8'(seq) ^ 8'h5A};
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_streams(int seq);
    for (int p = 0; p < NP; p++)
      for (int s = 0; s < NS; s++)
        streams[(p*NS+s)*W +: W] = val(p, s, seq);
  endtask

  task automatic strobe();
    @(negedge clk); smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
    strobes++;
  endtask

  task automatic pulse_byte();
    @(negedge clk); byte_rd = 1'b1;
    @(negedge clk); byte_rd = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  task automatic read_sample(string req, logic [W-1:0] exp);
    for (int b = 0; b < 3; b++) begin
      check(byte_out == exp[W-1-8*b -: 8], req, "byte", byte_out, exp[W-1-8*b -: 8]);
      pulse_byte();
    end
    check(byte_out == exp[W-1 -: 8], "R5", "wrap to top byte", byte_out, exp[W-1 -: 8]);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; smp_valid = 0; status_rd = 0; byte_rd = 0;
    phase_sel = 0; src_sel = 0; rate_sel = 0; irq_mask = 1; streams = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    strobes = 0; last = '0;
    check(irq_n == 1'b1, "R9", "irq_n after reset", irq_n, 1);
    check(overrun == 1'b0, "R9", "overrun after reset", overrun, 0);
    check(byte_out == 8'h00, "R9", "byte_out after reset", byte_out, 0);
  endtask

  task automatic t_select();
    int ps [5] = '{0, 1, 2, 0, 2};
    int ss [5] = '{0, 1, 4, 3, 2};
    rate_sel = 0; irq_mask = 1;
    for (int k = 0; k < 5; k++) begin
      set_streams(k + 1);
      phase_sel = 2'(ps[k]); src_sel = 3'(ss[k]);
      strobe();
      last = val(ps[k], ss[k], k + 1);
      check(irq_n == 1'b0, "R6", "irq after capture", irq_n, 0);
      read_sample("R1", last);
      check(irq_n == 1'b0, "R7", "irq held through reads", irq_n, 0);
      clear_status();
      check(irq_n == 1'b1, "R7", "irq cleared by status", irq_n, 1);
    end
  endtask

  task automatic t_badsel();
    set_streams(8'h40);
    phase_sel = 2'd3; src_sel = 3'd0; strobe();
    check(byte_out == last[W-1 -: 8], "R2", "phase 3 no capture", byte_out, last[W-1 -: 8]);
    check(irq_n == 1'b1, "R2", "phase 3 no irq", irq_n, 1);
    phase_sel = 2'd0; src_sel = 3'd5; strobe();
    check(byte_out == last[W-1 -: 8], "R2", "source 5 no capture", byte_out, last[W-1 -: 8]);
    src_sel = 3'd7; strobe();
    check(irq_n == 1'b1, "R2", "source 7 no irq", irq_n, 1);
  endtask

  task automatic t_rate();
    phase_sel = 2'd1; src_sel = 3'd2;
    for (int r = 1; r < 4; r++) begin
      rate_sel = 2'(r);
      for (int i = 0; i < 12; i++) begin
        int seq = 8'h80 + r*16 + i;
        bit keep = ((strobes & ((1 << r) - 1)) == 0);
        set_streams(seq);
        strobe();
        if (keep) last = val(1, 2, seq);
        check(byte_out == last[W-1 -: 8], "R3", "decimated sample", byte_out, last[W-1 -: 8]);
        check(irq_n == !keep, "R3", "irq on kept strobe only", irq_n, !keep);
        clear_status();
      end
    end
    rate_sel = 0;
  endtask

  task automatic t_mask();
    irq_mask = 0; set_streams(8'h21); strobe();
    last = val(1, 2, 8'h21);
    check(irq_n == 1'b1, "R6", "masked irq stays high", irq_n, 1);
    @(negedge clk); irq_mask = 1; #1;
    check(irq_n == 1'b0, "R6", "pending shows on unmask", irq_n, 0);
    clear_status();
    check(irq_n == 1'b1, "R6", "cleared after unmask", irq_n, 1);
  endtask

  task automatic t_overrun();
    set_streams(8'h31); strobe();
    pulse_byte();
    check(overrun == 1'b0, "R8", "no overrun yet", overrun, 0);
    set_streams(8'h32); strobe();
    last = val(1, 2, 8'h32);
    check(overrun == 1'b1, "R8", "overrun mid-read", overrun, 1);
    check(byte_out == last[W-1 -: 8], "R8", "pointer back to top", byte_out, last[W-1 -: 8]);
    clear_status();
    check(overrun == 1'b0, "R8", "status clears overrun", overrun, 0);
    set_streams(8'h33); strobe();
    last = val(1, 2, 8'h33);
    check(overrun == 1'b0, "R8", "capture at top byte no overrun", overrun, 0);
    clear_status();
  endtask

  task automatic t_collide();
    logic [W-1:0] prev = last;
    set_streams(8'h44);
    @(negedge clk); smp_valid = 1'b1; status_rd = 1'b1; #1;
    check(byte_out == prev[W-1 -: 8], "R4", "old sample before edge", byte_out, prev[W-1 -: 8]);
    @(negedge clk); smp_valid = 1'b0; status_rd = 1'b0;
    strobes++;
    last = val(1, 2, 8'h44);
    check(byte_out == last[W-1 -: 8], "R4", "new sample after edge", byte_out, last[W-1 -: 8]);
    check(irq_n == 1'b0, "R7", "capture beats status clear", irq_n, 0);
    clear_status();
  endtask

  initial begin
    t_reset();
    t_select();
    t_badsel();
    t_rate();
    t_mask();
    t_overrun();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule